// File: doc/BRIEF.md
# Charge-State Flag Detector

This block watches the measurements of a battery monitor once per conversion cycle. That cycle is about 3.5 s, and a single-cycle strobe marks each one. From those readings it keeps four status flags and a running current average. The flags are charge-complete, active-empty, standby-empty and learn-window-open.

The current average is the mean of the last eight current readings. It is refreshed on every eighth strobe. The full detector uses this average. It declares the pack charged only when the voltage has stayed above the charge threshold across two consecutive average refreshes, and both of those averages show a small positive charge current. The empty detector and the learn logic compare the voltage with the empty threshold and look at the two preceding current readings. The percentage inputs drive the hysteresis that clears the flags again.

The threshold bytes are scaled inside the block:

- A voltage threshold byte is worth 4 voltage LSBs.
- The minimum-charge-current byte is worth 32 current LSBs.
- The empty-current byte is worth 128 current LSBs.

Top module: `chg_flag_det`

## Requirements
- R1: On every eighth strobe counted from reset, the average output takes the sum of the eight most recent current samples (the one presented on that strobe included), arithmetically shifted right by 3. This rounds toward minus infinity. It holds its value at all other times.
- R2: The charge-complete flag sets on a refresh strobe when four things are true. The voltage is strictly above 4×charge-voltage-byte. The new average is greater than 0 and strictly below 32×min-current-byte. The previous refresh also met these conditions. The voltage qualified on every strobe since that previous refresh.
- R3: Any strobe whose voltage is not strictly above the charge threshold (equality included) discards a pending qualification, so two new qualifying refreshes are needed.
- R4: The charge-complete flag clears on a strobe with active percentage below 90. A strobe with active percentage of exactly 90 leaves it set. A set on the same strobe wins.
- R5: The active-empty flag sets on a strobe with voltage strictly below 4×empty-voltage-byte. Otherwise it clears on a strobe with active percentage above 5. At exactly 5 it holds.
- R6: The standby-empty flag sets on a strobe with standby percentage below 10 and clears on a strobe with standby percentage above 15. From 10 to 15 inclusive it holds.
- R7: The learn flag sets on a strobe when three things are true. The previous strobe's voltage was at or above the empty threshold. This strobe's voltage is below it. Both of the two previous strobes' currents were strictly below −128×empty-current-byte.
- R8: The learn flag clears in any cycle on the accumulator-zero level, the accumulator-load pulse or the sleep pulse, and on a strobe where charge-complete is detected. Clearing wins over setting.
- R9: Reset clears all flags and the average to 0. Apart from the learn clears of R8, no output changes in a cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cyc_i | input | 1 | One-cycle processing strobe |
| volt_i | input | 16 | Voltage reading, two's complement |
| curr_i | input | 16 | Current reading, two's complement, charge positive |
| act_pct_i | input | 8 | Remaining active capacity, percent |
| stby_pct_i | input | 8 | Remaining standby capacity, percent |
| acr_zero_i | input | 1 | Charge accumulator is zero |
| acr_load_i | input | 1 | Accumulator written or recalled (pulse) |
| sleep_i | input | 1 | Sleep entry (pulse) |
| vchg_thr_i | input | 8 | Charge voltage threshold byte |
| imin_thr_i | input | 8 | Minimum charge current byte |
| vemp_thr_i | input | 8 | Empty voltage threshold byte |
| iemp_thr_i | input | 8 | Empty current byte |
| chg_full_o | output | 1 | Charge-complete flag |
| act_empty_o | output | 1 | Active-empty flag |
| stby_empty_o | output | 1 | Standby-empty flag |
| learn_o | output | 1 | Learn-window flag |
| iavg_o | output | 16 | Eight-sample current average |

## Verification
The bench builds the block with its defaults: 16-bit readings, an eight-deep average and the hysteresis limits 90/5/10/15. With these values a full-detection sequence is only sixteen strobes long. Qualification restarts, floor rounding of negative averages and percentage edges exactly at the limits can therefore all be reached in a few hundred cycles. The threshold bytes are chosen small (charge 800, minimum current 64, empty 600, empty current 128). This puts the equality cases for voltage, average and current within easy reach of the stimulus.

// File: rtl/chg_flag_pkg.sv
package chg_flag_pkg;
  typedef struct packed {
    logic chg_full;
    logic act_empty;
    logic stby_empty;
    logic learn;
  } flag_t;
endpackage

// File: rtl/cfd_avg.sv
module cfd_avg #(
  parameter int CUR_W    = 16,
  parameter int AVG_LOG2 = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cyc_i,
  input  logic signed [CUR_W-1:0] curr_i,
  output logic                    upd_o,
  output logic signed [CUR_W-1:0] avg_nxt_o,
  output logic signed [CUR_W-1:0] iavg_o
);
  localparam int DEPTH = 1 << AVG_LOG2;
  localparam int SUM_W = CUR_W + AVG_LOG2;

  logic [AVG_LOG2-1:0]     ptr_q;
  logic signed [CUR_W-1:0] smp_q [DEPTH];
  logic signed [CUR_W-1:0] tap   [DEPTH];
  logic signed [SUM_W-1:0] sum;

  // the slot being written this strobe contributes the fresh sample
  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    assign tap[g] = (ptr_q == AVG_LOG2'(g)) ? curr_i : smp_q[g];
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < DEPTH; i++) sum = sum + SUM_W'(tap[i]);
  end

  assign upd_o     = cyc_i && (ptr_q == '1);
  assign avg_nxt_o = CUR_W'(sum >>> AVG_LOG2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      iavg_o <= '0;
      for (int i = 0; i < DEPTH; i++) smp_q[i] <= '0;
    end else if (cyc_i) begin
      smp_q[ptr_q] <= curr_i;
      ptr_q        <= ptr_q + 1'b1;
      if (upd_o) iavg_o <= avg_nxt_o;
    end
  end

  assert_avg_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_i |=> $stable(iavg_o));
endmodule

// File: rtl/cfd_full.sv
module cfd_full #(
  parameter int VOLT_W  = 16,
  parameter int CUR_W   = 16,
  parameter int PCT_W   = 8,
  parameter int THR_W   = 8,
  parameter int V_SH    = 2,
  parameter int I_SH    = 5,
  parameter int CLR_PCT = 90
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cyc_i,
  input  logic signed [VOLT_W-1:0] volt_i,
  input  logic [THR_W-1:0]         vchg_thr_i,
  input  logic [THR_W-1:0]         imin_thr_i,
  input  logic [PCT_W-1:0]         act_pct_i,
  input  logic                     upd_i,
  input  logic signed [CUR_W-1:0]  avg_nxt_i,
  output logic                     full_set_o,
  output logic                     chg_full_o
);
  localparam int VX_W = VOLT_W + 2;
  localparam int IX_W = CUR_W + 2;

  logic signed [VX_W-1:0] v_x, v_thr;
  logic signed [IX_W-1:0] a_x, i_thr;
  logic v_ok, qual, have_q;

  assign v_x   = VX_W'(volt_i);
  assign v_thr = $signed({{(VX_W-THR_W-V_SH){1'b0}}, vchg_thr_i, {V_SH{1'b0}}});
  assign a_x   = IX_W'(avg_nxt_i);
  assign i_thr = $signed({{(IX_W-THR_W-I_SH){1'b0}}, imin_thr_i, {I_SH{1'b0}}});

  assign v_ok       = v_x > v_thr;
  assign qual       = upd_i && v_ok && (a_x > 0) && (a_x < i_thr);
  assign full_set_o = qual && have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q     <= 1'b0;
      chg_full_o <= 1'b0;
    end else if (cyc_i) begin
      if (!v_ok)      have_q <= 1'b0;
      else if (upd_i) have_q <= qual;
      if (full_set_o)                        chg_full_o <= 1'b1;
      else if (act_pct_i < PCT_W'(CLR_PCT))  chg_full_o <= 1'b0;
    end
  end

  assert_no_set_low_v_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i && !v_ok && !chg_full_o |=> !chg_full_o);
  assert_full_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i && !v_ok && (act_pct_i < PCT_W'(CLR_PCT)) |=> !chg_full_o);
endmodule

// File: rtl/cfd_empty.sv
module cfd_empty #(
  parameter int VOLT_W  = 16,
  parameter int CUR_W   = 16,
  parameter int PCT_W   = 8,
  parameter int THR_W   = 8,
  parameter int V_SH    = 2,
  parameter int I_SH    = 7,
  parameter int CLR_PCT = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cyc_i,
  input  logic signed [VOLT_W-1:0] volt_i,
  input  logic signed [CUR_W-1:0]  curr_i,
  input  logic [THR_W-1:0]         vemp_thr_i,
  input  logic [THR_W-1:0]         iemp_thr_i,
  input  logic [PCT_W-1:0]         act_pct_i,
  input  logic                     full_set_i,
  input  logic                     acr_zero_i,
  input  logic                     acr_load_i,
  input  logic                     sleep_i,
  output logic                     act_empty_o,
  output logic                     learn_o
);
  localparam int VX_W = VOLT_W + 2;
  localparam int IX_W = CUR_W + 2;

  logic signed [VX_W-1:0]  v_x, v_thr;
  logic signed [IX_W-1:0]  i_lim, c1_x, c2_x;
  logic signed [CUR_W-1:0] c1_q, c2_q;
  logic v_lo, vprev_hi_q, learn_set, learn_clr;

  assign v_x   = VX_W'(volt_i);
  assign v_thr = $signed({{(VX_W-THR_W-V_SH){1'b0}}, vemp_thr_i, {V_SH{1'b0}}});
  assign i_lim = -$signed({{(IX_W-THR_W-I_SH){1'b0}}, iemp_thr_i, {I_SH{1'b0}}});
  assign c1_x  = IX_W'(c1_q);
  assign c2_x  = IX_W'(c2_q);
  assign v_lo  = v_x < v_thr;

  assign learn_set = cyc_i && vprev_hi_q && v_lo && (c1_x < i_lim) && (c2_x < i_lim);
  assign learn_clr = acr_zero_i || acr_load_i || sleep_i || full_set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_empty_o <= 1'b0;
      vprev_hi_q  <= 1'b0;
      c1_q        <= '0;
      c2_q        <= '0;
    end else if (cyc_i) begin
      if (v_lo)                              act_empty_o <= 1'b1;
      else if (act_pct_i > PCT_W'(CLR_PCT))  act_empty_o <= 1'b0;
      vprev_hi_q <= !v_lo;
      c1_q       <= curr_i;
      c2_q       <= c1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        learn_o <= 1'b0;
    else if (learn_clr) learn_o <= 1'b0;
    else if (learn_set) learn_o <= 1'b1;
  end

  assert_ae_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i && v_lo |=> act_empty_o);
  assert_learn_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acr_zero_i || acr_load_i || sleep_i) |=> !learn_o);
  assert_learn_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_i && !learn_o |=> !learn_o);
endmodule

// File: rtl/cfd_hyst.sv
module cfd_hyst #(
  parameter int PCT_W     = 8,
  parameter int SET_BELOW = 10,
  parameter int CLR_ABOVE = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_i,
  input  logic [PCT_W-1:0] pct_i,
  output logic             flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else if (cyc_i) begin
      if (pct_i < PCT_W'(SET_BELOW))      flag_o <= 1'b1;
      else if (pct_i > PCT_W'(CLR_ABOVE)) flag_o <= 1'b0;
    end
  end

  assert_hyst_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i && (pct_i > PCT_W'(CLR_ABOVE)) |=> !flag_o);
  assert_hyst_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_i && (pct_i < PCT_W'(SET_BELOW)) |=> flag_o);
endmodule

// File: rtl/chg_flag_det.sv
module chg_flag_det #(
  parameter int VOLT_W     = 16,
  parameter int CUR_W      = 16,
  parameter int PCT_W      = 8,
  parameter int THR_W      = 8,
  parameter int AVG_LOG2   = 3,
  parameter int VTHR_SH    = 2,
  parameter int IMIN_SH    = 5,
  parameter int IEMP_SH    = 7,
  parameter int FULL_CLR   = 90,
  parameter int AE_CLR     = 5,
  parameter int SE_SET     = 10,
  parameter int SE_CLR     = 15
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cyc_i,
  input  logic signed [VOLT_W-1:0] volt_i,
  input  logic signed [CUR_W-1:0]  curr_i,
  input  logic [PCT_W-1:0]         act_pct_i,
  input  logic [PCT_W-1:0]         stby_pct_i,
  input  logic                     acr_zero_i,
  input  logic                     acr_load_i,
  input  logic                     sleep_i,
  input  logic [THR_W-1:0]         vchg_thr_i,
  input  logic [THR_W-1:0]         imin_thr_i,
  input  logic [THR_W-1:0]         vemp_thr_i,
  input  logic [THR_W-1:0]         iemp_thr_i,
  output logic                     chg_full_o,
  output logic                     act_empty_o,
  output logic                     stby_empty_o,
  output logic                     learn_o,
  output logic signed [CUR_W-1:0]  iavg_o
);
  import chg_flag_pkg::*;

  flag_t flags;
  logic upd, full_set;
  logic signed [CUR_W-1:0] avg_nxt;

  cfd_avg #(.CUR_W(CUR_W), .AVG_LOG2(AVG_LOG2)) u_avg (
    .clk_i, .rst_ni, .cyc_i, .curr_i,
    .upd_o(upd), .avg_nxt_o(avg_nxt), .iavg_o(iavg_o)
  );

  cfd_full #(.VOLT_W(VOLT_W), .CUR_W(CUR_W), .PCT_W(PCT_W), .THR_W(THR_W),
             .V_SH(VTHR_SH), .I_SH(IMIN_SH), .CLR_PCT(FULL_CLR)) u_full (
    .clk_i, .rst_ni, .cyc_i, .volt_i, .vchg_thr_i, .imin_thr_i, .act_pct_i,
    .upd_i(upd), .avg_nxt_i(avg_nxt), .full_set_o(full_set),
    .chg_full_o(flags.chg_full)
  );

  cfd_empty #(.VOLT_W(VOLT_W), .CUR_W(CUR_W), .PCT_W(PCT_W), .THR_W(THR_W),
              .V_SH(VTHR_SH), .I_SH(IEMP_SH), .CLR_PCT(AE_CLR)) u_empty (
    .clk_i, .rst_ni, .cyc_i, .volt_i, .curr_i, .vemp_thr_i, .iemp_thr_i,
    .act_pct_i, .full_set_i(full_set), .acr_zero_i, .acr_load_i, .sleep_i,
    .act_empty_o(flags.act_empty), .learn_o(flags.learn)
  );

  cfd_hyst #(.PCT_W(PCT_W), .SET_BELOW(SE_SET), .CLR_ABOVE(SE_CLR)) u_sby (
    .clk_i, .rst_ni, .cyc_i, .pct_i(stby_pct_i), .flag_o(flags.stby_empty)
  );

  assign chg_full_o   = flags.chg_full;
  assign act_empty_o  = flags.act_empty;
  assign stby_empty_o = flags.stby_empty;
  assign learn_o      = flags.learn;

  assert_full_only_upd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd && !chg_full_o |=> !chg_full_o);
endmodule

// File: tb/chg_flag_det_tb.sv
module chg_flag_det_tb;
  logic clk = 1'b0, rst_n = 1'b0, cyc = 1'b0, mon_req = 1'b0;
  logic signed [15:0] volt = '0, curr = '0, iavg;
  logic [7:0] rarc = 8'd50, rsrc = 8'd50;
  logic [7:0] vchg = 8'd200, imin = 8'd2, vae = 8'd150, iae = 8'd1;
  logic azero = 1'b0, aload = 1'b0, slp = 1'b0;
  logic chgtf, aef, sef, learn;

  typedef struct {bit chg; bit ae; bit se; bit ln; int avg; string req;} exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0;

  int m_buf[8];
  int m_ptr = 0, m_iavg = 0, m_c1 = 0, m_c2 = 0;
  bit m_have = 0, m_chg = 0, m_ae = 0, m_se = 0, m_ln = 0, m_vpa = 0;

  always #4 clk = ~clk;

  chg_flag_det u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .volt_i(volt), .curr_i(curr),
    .act_pct_i(rarc), .stby_pct_i(rsrc), .acr_zero_i(azero), .acr_load_i(aload),
    .sleep_i(slp), .vchg_thr_i(vchg), .imin_thr_i(imin), .vemp_thr_i(vae),
    .iemp_thr_i(iae), .chg_full_o(chgtf), .act_empty_o(aef),
    .stby_empty_o(sef), .learn_o(learn), .iavg_o(iavg)
  );

  task automatic chk(string what, int act, int exp, string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_item(exp_t e);
    chk("chg_full", int'(chgtf), int'(e.chg), e.req);
    chk("act_empty", int'(aef), int'(e.ae), e.req);
    chk("stby_empty", int'(sef), int'(e.se), e.req);
    chk("learn", int'(learn), int'(e.ln), e.req);
    chk("iavg", int'(iavg), e.avg, e.req);
  endtask

  function automatic exp_t cur_exp(string req);
    exp_t e;
    e.chg = m_chg; e.ae = m_ae; e.se = m_se; e.ln = m_ln; e.avg = m_iavg; e.req = req;
    return e;
  endfunction

  task automatic model_step(int v, int c, int ra, int rs, bit az);
    bit v_ok, v_lo, upd, qual, fset, lset;
    int s, navg;
    v_ok = v > int'(vchg) * 4;
    v_lo = v < int'(vae) * 4;
    m_buf[m_ptr] = c;
    upd = (m_ptr == 7);
    m_ptr = (m_ptr + 1) % 8;
    s = 0;
    for (int i = 0; i < 8; i++) s += m_buf[i];
    navg = s >>> 3;
    qual = upd && v_ok && navg > 0 && navg < int'(imin) * 32;
    fset = qual && m_have;
    if (!v_ok) m_have = 0; else if (upd) m_have = qual;
    if (fset) m_chg = 1; else if (ra < 90) m_chg = 0;
    if (upd) m_iavg = navg;
    if (v_lo) m_ae = 1; else if (ra > 5) m_ae = 0;
    if (rs < 10) m_se = 1; else if (rs > 15) m_se = 0;
    lset = m_vpa && v_lo && m_c1 < -(int'(iae) * 128) && m_c2 < -(int'(iae) * 128);
    if (az || fset) m_ln = 0; else if (lset) m_ln = 1;
    m_vpa = !v_lo;
    m_c2 = m_c1;
    m_c1 = c;
  endtask

  task automatic strobe(int v, int c, int ra, int rs, bit az, string req);
    @(negedge clk);
    volt = 16'(v); curr = 16'(c); rarc = 8'(ra); rsrc = 8'(rs); azero = az;
    cyc = 1'b1; mon_req = 1'b1;
    model_step(v, c, ra, rs, az);
    q.push_back(cur_exp(req));
    @(negedge clk);
    cyc = 1'b0; mon_req = 1'b0; azero = 1'b0;
  endtask

  task automatic pulse(bit ld, bit sl, string req);
    @(negedge clk);
    aload = ld; slp = sl; mon_req = 1'b1;
    m_ln = 0;
    q.push_back(cur_exp(req));
    @(negedge clk);
    aload = 1'b0; slp = 1'b0; mon_req = 1'b0;
  endtask

  // monitor: pop one expectation per requested cycle, compare after the edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      if (mon_req) begin
        @(negedge clk);
        if (q.size() == 0) chk("queue", 0, 1, "SB");
        else begin e = q.pop_front(); cmp_item(e); end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_buf[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_item(cur_exp("R9 reset"));

    // R1 average: ramp, uniform negative, floor rounding of -5/8
    for (int i = 1; i <= 8; i++) strobe(700, i * 10, 50, 50, 0, "R1");
    for (int i = 0; i < 8; i++) strobe(700, -40, 50, 50, 0, "R1");
    for (int i = 0; i < 8; i++) strobe(700, (i == 0) ? 2 : -1, 50, 50, 0, "R1");

    // R2 full detect over two refreshes
    for (int i = 0; i < 16; i++) strobe(900, 40, 95, 50, 0, "R2");
    // R4 clear boundary
    strobe(700, 40, 90, 50, 0, "R4 hold at 90");
    strobe(700, 40, 89, 50, 0, "R4 clear");
    for (int i = 0; i < 6; i++) strobe(700, 40, 95, 50, 0, "R4");
    // R3 restart: one strobe at exactly the threshold mid-window
    for (int i = 0; i < 8; i++) strobe(900, 40, 95, 50, 0, "R3");
    for (int i = 0; i < 8; i++) strobe((i == 3) ? 800 : 900, 40, 95, 50, 0, "R3");
    for (int i = 0; i < 8; i++) strobe(900, 40, 95, 50, 0, "R3");
    strobe(700, 40, 89, 50, 0, "R4 clear");
    // R2 average equal to limit never qualifies
    for (int i = 0; i < 24; i++) strobe(900, 64, 95, 50, 0, "R2 limit");

    // R5 active-empty
    strobe(599, 0, 50, 50, 0, "R5 set");
    strobe(700, 0, 5, 50, 0, "R5 hold at 5");
    strobe(700, 0, 6, 50, 0, "R5 clear");
    strobe(600, 0, 50, 50, 0, "R5 equal no set");

    // R7 learn set and R8 clears
    strobe(700, -200, 50, 50, 0, "R7");
    strobe(700, -200, 50, 50, 0, "R7");
    strobe(500, -200, 50, 50, 0, "R7 set");
    pulse(0, 1, "R8 sleep");
    strobe(700, -200, 50, 50, 0, "R7");
    strobe(700, -200, 50, 50, 0, "R7");
    strobe(500, -200, 50, 50, 0, "R7 set");
    pulse(1, 0, "R8 acr load");
    strobe(700, -200, 50, 50, 0, "R7");
    strobe(700, -200, 50, 50, 0, "R7");
    strobe(500, -200, 50, 50, 0, "R7 set");
    strobe(700, -200, 50, 50, 1, "R8 acr zero");
    strobe(700, -128, 50, 50, 0, "R7");
    strobe(700, -128, 50, 50, 0, "R7");
    strobe(500, -128, 50, 50, 0, "R7 equal no set");
    strobe(700, -129, 50, 50, 0, "R7");
    strobe(700, -129, 50, 50, 0, "R7");
    strobe(500, -129, 50, 50, 0, "R7 boundary set");
    for (int i = 0; i < 24; i++) strobe(900, 40, 95, 50, 0, "R8 full clears learn");

    // R6 standby hysteresis
    strobe(700, 0, 95, 9, 0, "R6 set");
    strobe(700, 0, 95, 15, 0, "R6 hold");
    strobe(700, 0, 95, 16, 0, "R6 clear");
    strobe(700, 0, 95, 10, 0, "R6 no set");
    strobe(700, 0, 95, 12, 0, "R6 hold");

    // R9 no change without strobe
    @(negedge clk);
    rsrc = 8'd3; volt = 16'sd100; rarc = 8'd0;
    repeat (3) @(negedge clk);
    cmp_item(cur_exp("R9 no strobe"));

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule